// File: doc/BRIEF.md
# Replication-Aware Victim Selector

This block picks the way to replace in one set of a four-way private cache that shares capacity with peer caches on the same die. Every way keeps a valid bit, a hint that the line is the only copy on the die (the singlet hint), a hint that the line arrived from a peer and has not been used since (the guest hint), and a two-bit recency age. When a fill is requested, the block names the way to overwrite and says whether the displaced line should be forwarded to a peer cache instead of being dropped.

The choice avoids lines that exist elsewhere on the die, so the set keeps unique lines. A line forwarded into this cache is a guest. It gets one chance: if it is displaced again before the local processor uses it, it is dropped. Two 8-bit probabilities, compared against a free-running 16-bit LFSR, set how often the biased choice is used and how often a unique victim is forwarded. With both at zero the set behaves as a plain LRU private cache. The hints only steer the choice, so a stale hint never affects correctness.

Top module: `coop_victim_sel`

## Requirements
- R1: When at least one way is invalid, the victim is the lowest-numbered invalid way and the forward flag is 0.
- R2: When all ways are valid and the cooperation throttle applies, the victim is the least recently used way among those whose singlet hint is clear, if any such way exists.
- R3: When every way is a singlet, or the cooperation throttle does not apply, the victim is the least recently used way. Every hit and every fill makes its way the most recently used.
- R4: The forward flag is 1 only when all of these hold: the victim is valid, its singlet hint is set, its guest hint is clear, the request is a local fill, and the spill throttle applies.
- R5: A fill with `fill_is_spill` = 1 never raises the forward flag. The incoming line is installed with both its singlet hint and its guest hint set, so a later eviction of it while still unused is not forwarded.
- R6: A processor hit on a way clears that way's guest hint, so the line can be forwarded again when it is later evicted as a singlet.
- R7: A local fill (`fill_is_spill` = 0) installs the line with both hints clear.
- R8: A singlet notification sets the singlet hint of a valid way. Nothing else sets the singlet hint, apart from a spill arrival.
- R9: A probability value of 255 means the throttle always applies and 0 means it never applies. With both probabilities at 0 the selection is plain LRU and nothing is forwarded.
- R10: The result appears in the cycle after `fill_req`, with `vict_valid` high for exactly one cycle per request. Back-to-back requests each see the state left by the previous fill.
- R11: A hit presented in the same cycle as `fill_req` is ignored.
- R12: After reset `vict_valid` is 0 and all ways are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req | input | 1 | Request a victim and install a line in it this cycle |
| fill_is_spill | input | 1 | The line being installed is a forwarded line from a peer |
| hit_valid | input | 1 | Processor hit on a way of this set |
| hit_way | input | 2 | Way that was hit |
| sing_valid | input | 1 | Advisory notice that a line is now the last copy on the die |
| sing_way | input | 2 | Way named by the notice |
| coop_prob | input | 8 | Probability of using the replication-aware choice |
| spill_prob | input | 8 | Probability of forwarding a unique victim |
| vict_valid | output | 1 | Result strobe, one cycle after the request |
| vict_way | output | 2 | Chosen victim way |
| vict_fwd | output | 1 | Forward the displaced line to a peer cache |

## Verification
The hardest state to reach is a guest line that has become the least recently used way while every other way is a singlet. Only in that state does the once-only forwarding rule decide the forward flag. The stimulus reaches it in three steps: it delivers a spill arrival while all ways are singlets, touches each of the other three ways with hits so the guest ages to the bottom, and then issues a local fill. A second pass hits the guest before it ages out and expects the line to be forwarded. The hit that coincides with a fill is checked through the victim order of the request that follows.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    localparam int WAYS    = 4;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int AGE_W   = $clog2(WAYS);
    localparam int PROB_W  = 8;
    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(WAYS - 1);

    typedef struct packed {
        logic             valid;
        logic             singlet;
        logic             guest;
        logic [AGE_W-1:0] age;
    } way_hint_t;

    typedef struct packed {
        logic [WAY_W-1:0] way;
        logic             fwd;
    } victim_t;

    function automatic logic throttle_hit(input logic [PROB_W-1:0] prob,
                                          input logic [PROB_W-1:0] rnd);
        return (prob == {PROB_W{1'b1}}) || (rnd < prob);
    endfunction

endpackage

// File: rtl/cvs_throttle.sv
module cvs_throttle
    import cvs_pkg::*;
#(
    parameter int                LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PROB_W-1:0] coop_prob,
    input  logic [PROB_W-1:0] spill_prob,
    output logic              coop_on,
    output logic              spill_on
);

    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    assign fb = ^(lfsr_q & TAPS);

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= SEED;
        else     lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
    end

    assign coop_on  = throttle_hit(coop_prob,  lfsr_q[PROB_W-1:0]);
    assign spill_on = throttle_hit(spill_prob, lfsr_q[LFSR_W-1 -: PROB_W]);

    // R9 guard: a saturated probability must always apply
    always_ff @(posedge clk) begin
        if (!rst && coop_prob == {PROB_W{1'b1}})
            a_r9_coop_saturated: assert (coop_on);
        if (!rst && spill_prob == '0)
            a_r9_spill_zero: assert (!spill_on);
    end

endmodule

// File: rtl/cvs_set_state.sv
module cvs_set_state
    import cvs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             fill_is_spill,
    input  logic             hit_valid,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             sing_valid,
    input  logic [WAY_W-1:0] sing_way,
    output way_hint_t        hints [WAYS]
);

    logic             hit_en;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    logic [AGE_W-1:0] touch_age;

    assign hit_en    = hit_valid && !fill_en;
    assign touch_en  = fill_en || hit_en;
    assign touch_way = fill_en ? fill_way : hit_way;
    assign touch_age = hints[touch_way].age;

    for (genvar i = 0; i < WAYS; i++) begin : g_way
        always_ff @(posedge clk) begin
            if (rst) begin
                hints[i].valid   <= 1'b0;
                hints[i].singlet <= 1'b0;
                hints[i].guest   <= 1'b0;
                hints[i].age     <= AGE_W'(i);
            end else begin
                if (touch_en) begin
                    if (touch_way == WAY_W'(i))
                        hints[i].age <= '0;
                    else if (hints[i].age < touch_age)
                        hints[i].age <= hints[i].age + 1'b1;
                end
                if (fill_en && fill_way == WAY_W'(i)) begin
                    hints[i].valid   <= 1'b1;
                    hints[i].singlet <= fill_is_spill;
                    hints[i].guest   <= fill_is_spill;
                end else begin
                    if (hit_en && hit_way == WAY_W'(i))
                        hints[i].guest <= 1'b0;
                    if (sing_valid && sing_way == WAY_W'(i) && hints[i].valid)
                        hints[i].singlet <= 1'b1;
                end
            end
        end
    end

    // R3: a hit makes its way the most recent
    a_r3_hit_mru: assert property (@(posedge clk) disable iff (rst)
        hit_en |=> hints[$past(hit_way)].age == '0);

    // R6: a hit leaves no guest hint behind
    a_r6_hit_clears_guest: assert property (@(posedge clk) disable iff (rst)
        hit_en |=> !hints[$past(hit_way)].guest);

endmodule

// File: rtl/cvs_pick.sv
module cvs_pick
    import cvs_pkg::*;
(
    input  way_hint_t hints [WAYS],
    input  logic      coop_on,
    input  logic      spill_on,
    input  logic      fill_is_spill,
    output victim_t   choice
);

    logic             any_inv;
    logic [WAY_W-1:0] inv_way;
    logic             any_rep;
    logic [WAY_W-1:0] rep_way;
    logic [AGE_W-1:0] rep_age;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] pick_way;
    way_hint_t        pick_h;

    always_comb begin
        any_inv = 1'b0;
        inv_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!hints[i].valid) begin
                any_inv = 1'b1;
                inv_way = WAY_W'(i);
            end
        end

        any_rep = 1'b0;
        rep_way = '0;
        rep_age = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hints[i].valid && !hints[i].singlet &&
                (!any_rep || hints[i].age > rep_age)) begin
                any_rep = 1'b1;
                rep_way = WAY_W'(i);
                rep_age = hints[i].age;
            end
        end

        lru_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hints[i].age == AGE_OLDEST) lru_way = WAY_W'(i);
        end

        if (any_inv)                 pick_way = inv_way;
        else if (coop_on && any_rep) pick_way = rep_way;
        else                         pick_way = lru_way;

        pick_h        = hints[pick_way];
        choice.way    = pick_way;
        choice.fwd    = pick_h.valid && pick_h.singlet && !pick_h.guest &&
                        !fill_is_spill && spill_on;
    end

endmodule

// File: rtl/coop_victim_sel.sv
module coop_victim_sel
    import cvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_req,
    input  logic              fill_is_spill,
    input  logic              hit_valid,
    input  logic [WAY_W-1:0]  hit_way,
    input  logic              sing_valid,
    input  logic [WAY_W-1:0]  sing_way,
    input  logic [PROB_W-1:0] coop_prob,
    input  logic [PROB_W-1:0] spill_prob,
    output logic              vict_valid,
    output logic [WAY_W-1:0]  vict_way,
    output logic              vict_fwd
);

    way_hint_t hints [WAYS];
    victim_t   choice;
    logic      coop_on;
    logic      spill_on;

    cvs_throttle u_throttle (
        .clk        (clk),
        .rst        (rst),
        .coop_prob  (coop_prob),
        .spill_prob (spill_prob),
        .coop_on    (coop_on),
        .spill_on   (spill_on)
    );

    cvs_set_state u_state (
        .clk           (clk),
        .rst           (rst),
        .fill_en       (fill_req),
        .fill_way      (choice.way),
        .fill_is_spill (fill_is_spill),
        .hit_valid     (hit_valid),
        .hit_way       (hit_way),
        .sing_valid    (sing_valid),
        .sing_way      (sing_way),
        .hints         (hints)
    );

    cvs_pick u_pick (
        .hints         (hints),
        .coop_on       (coop_on),
        .spill_on      (spill_on),
        .fill_is_spill (fill_is_spill),
        .choice        (choice)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vict_valid <= 1'b0;
            vict_way   <= '0;
            vict_fwd   <= 1'b0;
        end else begin
            vict_valid <= fill_req;
            if (fill_req) begin
                vict_way <= choice.way;
                vict_fwd <= choice.fwd;
            end
        end
    end

    // R1 and R4: the chosen way agrees with the per-way state
    always_ff @(posedge clk) begin
        if (!rst && fill_req) begin
            a_r1_invalid_first: assert (hints[0].valid && hints[1].valid &&
                                        hints[2].valid && hints[3].valid ||
                                        !hints[choice.way].valid);
            if (choice.fwd)
                a_r4_fwd_unique: assert (hints[choice.way].singlet &&
                                         !hints[choice.way].guest);
        end
    end

    // R5: a spill arrival never forwards its victim
    a_r5_spill_no_fwd: assert property (@(posedge clk) disable iff (rst)
        fill_req && fill_is_spill |=> !vict_fwd);

    // R10: one strobe per request, one cycle later
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> vict_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !fill_req |=> !vict_valid);

endmodule

// File: tb/coop_victim_sel_test.sv
module coop_victim_sel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fill_req = 1'b0;
    logic       fill_is_spill = 1'b0;
    logic       hit_valid = 1'b0;
    logic [1:0] hit_way = '0;
    logic       sing_valid = 1'b0;
    logic [1:0] sing_way = '0;
    logic [7:0] coop_prob = 8'd255;
    logic [7:0] spill_prob = 8'd255;
    logic       vict_valid;
    logic [1:0] vict_way;
    logic       vict_fwd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] way;
        logic       fwd;
        string      req;
    } exp_t;

    exp_t sb [$];

    always #5 clk = ~clk;

    coop_victim_sel uut (
        .clk           (clk),
        .rst           (rst),
        .fill_req      (fill_req),
        .fill_is_spill (fill_is_spill),
        .hit_valid     (hit_valid),
        .hit_way       (hit_way),
        .sing_valid    (sing_valid),
        .sing_way      (sing_way),
        .coop_prob     (coop_prob),
        .spill_prob    (spill_prob),
        .vict_valid    (vict_valid),
        .vict_way      (vict_way),
        .vict_fwd      (vict_fwd)
    );

    // monitor: pops an expectation for every result strobe
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && vict_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R10: strobe with nothing pending (way=%0d fwd=%0d), expected no strobe",
                             vict_way, vict_fwd);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (vict_way !== e.way || vict_fwd !== e.fwd) begin
                        fails++;
                        $display("FAIL %s: way=%0d fwd=%0d, expected way=%0d fwd=%0d",
                                 e.req, vict_way, vict_fwd, e.way, e.fwd);
                    end
                end
            end
        end
    end

    task automatic fill(input bit spl, input int hw, input logic [1:0] ew,
                        input logic ef, input string req);
        exp_t e;
        fill_req      = 1'b1;
        fill_is_spill = spl;
        hit_valid     = (hw >= 0);
        hit_way       = 2'(hw < 0 ? 0 : hw);
        e.way = ew;
        e.fwd = ef;
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        fill_req      = 1'b0;
        fill_is_spill = 1'b0;
        hit_valid     = 1'b0;
    endtask

    task automatic hit(input logic [1:0] w);
        hit_valid = 1'b1;
        hit_way   = w;
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic note(input logic [1:0] w);
        sing_valid = 1'b1;
        sing_way   = w;
        @(negedge clk);
        sing_valid = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (vict_valid !== 1'b0) begin
            fails++;
            $display("FAIL R12: vict_valid=%0d after reset, expected 0", vict_valid);
        end

        // R12/R1: empty set fills lowest invalid way first, back to back (R10)
        fill(0, -1, 2'd0, 1'b0, "R12 first fill");
        fill(0, -1, 2'd1, 1'b0, "R1 invalid way 1");
        fill(0, -1, 2'd2, 1'b0, "R1 invalid way 2");
        fill(0, -1, 2'd3, 1'b0, "R1 invalid way 3");

        // R8/R2: ways 0,1 unique; LRU replicate is way 2
        note(2'd0);
        note(2'd1);
        fill(0, -1, 2'd2, 1'b0, "R2 lru replicate");
        note(2'd2);
        note(2'd3);
        // R3/R4: all unique -> LRU way 0, forwarded
        fill(0, -1, 2'd0, 1'b1, "R4 unique lru forwarded");

        // R5: spill arrival never forwards; its guest line is later dropped
        note(2'd0);
        fill(1, -1, 2'd1, 1'b0, "R5 spill arrival no fwd");
        hit(2'd0);
        hit(2'd2);
        hit(2'd3);
        fill(0, -1, 2'd1, 1'b0, "R5 unused guest dropped");

        // R6/R7: local fill of way 1 left it a replicate; mark unique
        note(2'd1);
        fill(1, -1, 2'd0, 1'b0, "R5 spill over unique lru");
        hit(2'd0);
        hit(2'd1);
        hit(2'd3);
        hit(2'd2);
        fill(0, -1, 2'd0, 1'b1, "R6 reused guest forwarded");

        // R9: cooperation off -> plain LRU ignores replicate way 0 (R7)
        coop_prob = 8'd0;
        fill(0, -1, 2'd1, 1'b1, "R9 coop off plain lru");
        spill_prob = 8'd0;
        fill(0, -1, 2'd3, 1'b0, "R9 both zero no fwd");
        coop_prob  = 8'd255;
        spill_prob = 8'd255;
        fill(0, -1, 2'd0, 1'b0, "R2 lru among replicates");

        // R11: hit on way 1 alongside fill is ignored
        note(2'd0);
        note(2'd1);
        note(2'd2);
        note(2'd3);
        fill(0, 1, 2'd2, 1'b1, "R11 fill with hit");
        coop_prob = 8'd0;
        fill(0, -1, 2'd1, 1'b1, "R11 hit ignored order");

        // R10: back-to-back with plain policy
        spill_prob = 8'd0;
        fill(0, -1, 2'd3, 1'b0, "R10 back to back first");
        fill(0, -1, 2'd0, 1'b0, "R10 back to back second");

        @(negedge clk);
        @(negedge clk);
        checks++;
        if (vict_valid !== 1'b0 || sb.size() != 0) begin
            fails++;
            $display("FAIL R10: strobe=%0d pending=%0d after idle, expected 0 and 0",
                     vict_valid, sb.size());
        end
        done = 1'b1;
        report();
    end

endmodule